// File: doc/BRIEF.md
# Mode-Switchable Dual/Single Line Decoder

This block turns a small binary address into a set of decode lines. A mode input repartitions one datapath between two uses. In the first, it is a pair of independent 2-to-4 decoders, each with its own address, its own pair of active-low enables and its own output polarity. In the second, it is one 3-to-8 decoder that spans all eight lines. In that case the lower half serves indices 0–3 and the upper half serves indices 4–7.

A line is either active-high, where the selected line goes high while the rest stay low, or active-low, the complement. Each half has its own polarity select, and a common select can force both halves to active-high. The effective polarity of a half is the OR of its own select and the common select, so every combination of the three polarity bits has a defined result.

The decode logic is combinational. An optional output register, chosen by a parameter, adds one clock of latency and a synchronous active-low reset for the outputs.

Top module: `mode_decoder`

## Requirements
- R1: In dual mode (mode=0), with both en_a_n bits low, the one line among dec_out[3:0] whose index equals addr_a[1:0] is at the active level of the lower half, and lines 0–3 are otherwise idle.
- R2: In dual mode, with both en_b_n bits low, the one line dec_out[4+k] with k equal to addr_b is at the active level of the upper half, and lines 4–7 are otherwise idle.
- R3: In single mode (mode=1), with all four enable inputs low, only line dec_out[n] is at its active level, where n = {addr_a[2], addr_a[1], addr_a[0]} and addr_a[2] is the most significant bit (address 5 selects dec_out[5] only).
- R4: addr_a[2] has no effect in dual mode, and addr_b has no effect in single mode.
- R5: In dual mode, a high bit in en_a_n puts all of lines 0–3 at their idle level, and a high bit in en_b_n does the same for lines 4–7. Each half is unaffected by the other half's enables.
- R6: In single mode, a high bit in any of en_a_n[1:0] or en_b_n[1:0] puts all eight lines at their idle level. This includes the case where a paired enable bit disagrees with its partner.
- R7: Lines 0–3 are active-high when pol_a OR pol_c is 1 and active-low otherwise. Lines 4–7 are active-high when pol_b OR pol_c is 1 and active-low otherwise. The idle level is the complement of the active level.
- R8: Each half never has more than one line at its active level.
- R9: With REG_OUT=1, dec_out shows the decode of the inputs sampled at the previous rising clock edge. A clock edge with rst_n low sets dec_out to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| mode | input | 1 | 0: two 2-to-4 decoders, 1: one 3-to-8 decoder |
| addr_a | input | SEL_W+1 | Lower-half address; the top bit is the MSB in single mode |
| addr_b | input | SEL_W | Upper-half address in dual mode |
| en_a_n | input | 2 | Active-low enables of the lower half |
| en_b_n | input | 2 | Active-low enables of the upper half |
| pol_a | input | 1 | Polarity select of lines 0–3 (1 = active-high) |
| pol_b | input | 1 | Polarity select of lines 4–7 (1 = active-high) |
| pol_c | input | 1 | Common polarity select, ORed into both halves |
| dec_out | output | 2*2^SEL_W | Decode lines |

## Verification
The bench builds the block with SEL_W=2 and REG_OUT=1. At SEL_W=2 the thirteen input bits give only 8192 combinations, so every mode, enable, address and polarity combination is applied and compared against an independent model. That sweep covers the enable disagreements, the ignored address bits and the polarity settings outside the usual ones. The registered output gives every result a fixed one-cycle latency for the scoreboard. It also brings the synchronous clearing under reset within reach of the checks.

// File: rtl/mdec_pkg.sv
// Shared definitions for the mode-switchable decoder.
// Assumes exactly two halves; the half width is a module parameter.
package mdec_pkg;
    typedef enum logic {
        MODE_DUAL   = 1'b0,
        MODE_SINGLE = 1'b1
    } mdec_mode_e;

    localparam int HALVES = 2;
endpackage

// File: rtl/mdec_route.sv
// Mode routing: turns the raw mode, address, enable and polarity inputs into
// a per-half enable, select and polarity. In single mode the top address bit
// chooses the half, and all four enables must be low.
// Assumes two halves of 2**SEL_W lines each.
module mdec_route
    import mdec_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic                           mode,
    input  logic [SEL_W:0]                 addr_a,
    input  logic [SEL_W-1:0]               addr_b,
    input  logic [1:0]                     en_a_n,
    input  logic [1:0]                     en_b_n,
    input  logic                           pol_a,
    input  logic                           pol_b,
    input  logic                           pol_c,
    output logic [HALVES-1:0]              half_on,
    output logic [HALVES-1:0][SEL_W-1:0]   half_sel,
    output logic [HALVES-1:0]              half_hi
);
    logic all_on;

    // Effective polarity: a half's own select ORed with the common select.
    always_comb begin
        half_hi[0] = pol_a | pol_c;
        half_hi[1] = pol_b | pol_c;
    end

    // Pick enable and select per half according to the mode.
    always_comb begin
        all_on = ~|{en_a_n, en_b_n};
        if (mdec_mode_e'(mode) == MODE_SINGLE) begin
            half_on[0]  = all_on & ~addr_a[SEL_W];
            half_on[1]  = all_on &  addr_a[SEL_W];
            half_sel[0] = addr_a[SEL_W-1:0];
            half_sel[1] = addr_a[SEL_W-1:0];
        end else begin
            half_on[0]  = ~|en_a_n;
            half_on[1]  = ~|en_b_n;
            half_sel[0] = addr_a[SEL_W-1:0];
            half_sel[1] = addr_b;
        end
    end
endmodule

// File: rtl/mdec_half.sv
// One-of-N decode of one half with selectable polarity.
// When disabled, every line sits at the idle level (the complement of active).
module mdec_half #(
    parameter int SEL_W  = 2,
    localparam int HALF_N = 1 << SEL_W
) (
    input  logic              on,
    input  logic [SEL_W-1:0]  sel,
    input  logic              act_high,
    output logic [HALF_N-1:0] lines
);
    // Compare each line index to the select and apply the polarity.
    always_comb begin
        for (int i = 0; i < HALF_N; i++) begin
            lines[i] = (on && (sel == SEL_W'(i))) ? act_high : ~act_high;
        end
    end
endmodule

// File: rtl/mdec_outreg.sv
// Optional output stage: a wire when REG_OUT is 0, one register when it is 1.
// The register clears to zero on a clock edge with rst_n low.
module mdec_outreg #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        // Register the decoded lines, with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_wire
        // Pass the decoded lines straight through.
        always_comb q = d;
    end
endmodule

// File: rtl/mode_decoder.sv
// Top of the mode-switchable decoder: routing, two half decoders and the
// optional output register. Assumes clk and rst_n matter only when REG_OUT=1.
module mode_decoder
    import mdec_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int HALF_N = 1 << SEL_W,
    localparam int LINES  = HALVES * HALF_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic [SEL_W:0]    addr_a,
    input  logic [SEL_W-1:0]  addr_b,
    input  logic [1:0]        en_a_n,
    input  logic [1:0]        en_b_n,
    input  logic              pol_a,
    input  logic              pol_b,
    input  logic              pol_c,
    output logic [LINES-1:0]  dec_out
);
    logic [HALVES-1:0]            half_on;
    logic [HALVES-1:0][SEL_W-1:0] half_sel;
    logic [HALVES-1:0]            half_hi;
    logic [LINES-1:0]             next_lines;

    mdec_route #(.SEL_W(SEL_W)) u_route (
        .mode     (mode),
        .addr_a   (addr_a),
        .addr_b   (addr_b),
        .en_a_n   (en_a_n),
        .en_b_n   (en_b_n),
        .pol_a    (pol_a),
        .pol_b    (pol_b),
        .pol_c    (pol_c),
        .half_on  (half_on),
        .half_sel (half_sel),
        .half_hi  (half_hi)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        mdec_half #(.SEL_W(SEL_W)) u_half (
            .on       (half_on[h]),
            .sel      (half_sel[h]),
            .act_high (half_hi[h]),
            .lines    (next_lines[h*HALF_N +: HALF_N])
        );
    end

    mdec_outreg #(.W(LINES), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_lines),
        .q     (dec_out)
    );
endmodule

// File: rtl/mdec_chk.sv
// Property checker for mode_decoder, attached by bind. It aligns the inputs
// with the output latency, removes each half's polarity, and checks the
// decode rules on the normalised lines (1 = active).
module mdec_chk #(
    parameter int SEL_W   = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int HALF_N = 1 << SEL_W,
    localparam int LINES  = 2 * HALF_N
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode,
    input logic [SEL_W:0]    addr_a,
    input logic [SEL_W-1:0]  addr_b,
    input logic [1:0]        en_a_n,
    input logic [1:0]        en_b_n,
    input logic              pol_a,
    input logic              pol_b,
    input logic              pol_c,
    input logic [LINES-1:0]  dec_out
);
    logic             d_mode, d_pa, d_pb, d_pc;
    logic [SEL_W:0]   d_a;
    logic [SEL_W-1:0] d_b;
    logic [1:0]       d_ea, d_eb;
    logic             primed;
    logic [LINES-1:0] norm;

    if (REG_OUT) begin : g_dly
        // Delay the inputs by the output register's latency.
        always_ff @(posedge clk) begin
            d_mode <= mode;  d_a <= addr_a; d_b <= addr_b;
            d_ea   <= en_a_n; d_eb <= en_b_n;
            d_pa   <= pol_a; d_pb <= pol_b; d_pc <= pol_c;
        end
    end else begin : g_now
        // No latency: use the inputs directly.
        always_comb begin
            d_mode = mode;  d_a = addr_a; d_b = addr_b;
            d_ea   = en_a_n; d_eb = en_b_n;
            d_pa   = pol_a; d_pb = pol_b; d_pc = pol_c;
        end
    end

    // Arm the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // Normalise: flip each half whose effective polarity is active-low.
    always_comb norm = dec_out ^ {{HALF_N{~(d_pb | d_pc)}}, {HALF_N{~(d_pa | d_pc)}}};

    // R8
    half_a_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> $onehot0(norm[HALF_N-1:0]));
    // R8
    half_b_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> $onehot0(norm[LINES-1:HALF_N]));
    // R5
    dual_a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !d_mode && (d_ea != 2'b00)) |-> (norm[HALF_N-1:0] == '0));
    // R5
    dual_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !d_mode && (d_eb != 2'b00)) |-> (norm[LINES-1:HALF_N] == '0));
    // R6
    single_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && d_mode && ({d_ea, d_eb} != 4'b0000)) |-> (norm == '0));
    // R3
    single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && d_mode && ({d_ea, d_eb} == 4'b0000)) |-> (norm == (LINES'(1) << d_a)));
    // R1
    dual_a_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !d_mode && (d_ea == 2'b00)) |->
        (norm[HALF_N-1:0] == (HALF_N'(1) << d_a[SEL_W-1:0])));
    // R2
    dual_b_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !d_mode && (d_eb == 2'b00)) |->
        (norm[LINES-1:HALF_N] == (HALF_N'(1) << d_b)));
endmodule

bind mode_decoder mdec_chk #(.SEL_W(SEL_W), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .addr_a  (addr_a),
    .addr_b  (addr_b),
    .en_a_n  (en_a_n),
    .en_b_n  (en_b_n),
    .pol_a   (pol_a),
    .pol_b   (pol_b),
    .pol_c   (pol_c),
    .dec_out (dec_out)
);

// File: tb/sim_mode_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies inputs on the falling edge and queues
// the expected lines; the monitor compares 1 ns after each rising edge.
module sim_mode_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode;
    logic [2:0] addr_a;
    logic [1:0] addr_b, en_a_n, en_b_n;
    logic       pol_a, pol_b, pol_c;
    logic [7:0] dec_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit run    = 1'b0;

    logic [7:0] exp_q [$];
    logic [1:0] hi_q  [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    mode_decoder #(.SEL_W(2), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr_a(addr_a), .addr_b(addr_b),
        .en_a_n(en_a_n), .en_b_n(en_b_n), .pol_a(pol_a), .pol_b(pol_b),
        .pol_c(pol_c), .dec_out(dec_out)
    );

    // Independent model of the requirements.
    function automatic logic [7:0] model(input logic [12:0] v);
        logic m; logic [2:0] a; logic [1:0] b, ea, eb; logic pa, pb, pc;
        logic [7:0] r;
        {m, a, b, ea, eb, pa, pb, pc} = v;
        for (int i = 0; i < 8; i++) begin
            logic hit, hi;
            if (m)          hit = (ea == 2'b00) && (eb == 2'b00) && (a == 3'(i));
            else if (i < 4) hit = (ea == 2'b00) && (a[1:0] == 2'(i));
            else            hit = (eb == 2'b00) && (b == 2'(i - 4));
            hi   = ((i < 4) ? pa : pb) | pc;
            r[i] = hi ? hit : ~hit;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [12:0] v);
        logic m; logic [2:0] a; logic [1:0] b, ea, eb; logic pa, pb, pc;
        string s;
        {m, a, b, ea, eb, pa, pb, pc} = v;
        if (m) begin
            s = ({ea, eb} != 4'b0) ? "R6" : "R3";
            if (b != 2'b0) s = {s, " R4"};
        end else begin
            s = ((ea != 2'b0) || (eb != 2'b0)) ? "R5 R1 R2" : "R1 R2";
            if (a[2]) s = {s, " R4"};
        end
        return {s, " R7"};
    endfunction

    task automatic drive(input logic [12:0] v, input logic [7:0] exp, input string tag);
        @(negedge clk);
        {mode, addr_a, addr_b, en_a_n, en_b_n, pol_a, pol_b, pol_c} = v;
        exp_q.push_back(exp);
        hi_q.push_back({v[1] | v[0], v[2] | v[0]});
        tag_q.push_back(tag);
    endtask

    // Monitor: pop one expected item per cycle and compare.
    always @(posedge clk) begin
        #1;
        if (run && exp_q.size() > 0) begin
            logic [7:0] e; logic [1:0] h; string t; logic [7:0] n;
            e = exp_q.pop_front(); h = hi_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (dec_out !== e) begin
                errors++;
                $display("FAIL %s (R9 latency): actual=%b expected=%b", t, dec_out, e);
            end
            n = dec_out ^ {{4{~h[1]}}, {4{~h[0]}}};
            checks++;
            if ($countones(n[3:0]) > 1 || $countones(n[7:4]) > 1) begin
                errors++;
                $display("FAIL R8: actual=%b expected at most one active line per half", dec_out);
            end
        end
    end

    initial begin
        // Inputs that would decode to 8'h08 if not held in reset.
        {mode, addr_a, addr_b, en_a_n, en_b_n, pol_a, pol_b, pol_c} = 13'b1_011_00_00_00_001;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            checks++;
            if (dec_out !== 8'h00) begin
                errors++;
                $display("FAIL R9 reset: actual=%b expected=%b", dec_out, 8'h00);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;
        // Directed: single mode address 5, active-high.
        drive(13'b1_101_00_00_00_001, 8'h20, "R3 directed");
        // Directed: dual, lower active-high addr 2, upper active-low addr 1.
        drive(13'b0_010_01_00_00_100, 8'hD4, "R1 R2 R7 directed");
        // Directed: single, one paired enable disagreeing, active-high -> all idle.
        drive(13'b1_010_00_10_00_001, 8'h00, "R6 directed");
        // Directed: dual, lower disabled active-low, upper addr 3 active-high.
        drive(13'b0_000_11_01_00_010, 8'h8F, "R5 directed");
        // Directed: single mode, addr_b nonzero ignored.
        drive(13'b1_110_11_00_00_001, 8'h40, "R4 directed");
        // Exhaustive sweep.
        for (int v = 0; v < 8192; v++) begin
            drive(13'(v), model(13'(v)), tag_of(13'(v)));
        end
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: actual=%0d pending expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule